// File: doc/BRIEF.md
# Auto Refresh Scheduler

This block sits beside the main command scheduler of a DRAM controller. It decides when the memory needs an Auto Refresh and then issues it. An interval timer produces one refresh obligation per average refresh period. That period is the 64 ms retention window divided by the number of rows, converted to clock cycles at elaboration. Each obligation is added to a small saturating backlog. While the backlog is non-zero, the block raises a request toward the main scheduler and waits for a grant. Once granted, it owns the command pins. It closes any open bank with a precharge-all, waits out the precharge period, and issues the refresh command. It then keeps the bus for the refresh cycle time before handing it back.

The main scheduler supplies a per-bank open mask and a precharge-period-done flag. The flag says that every bank has been idle for at least tRP since the last precharge sent to it. The block drives no row or bank address for the refresh, because the device produces those internally. Only the A10 "all banks" bit is driven, and only for the precharge-all. An urgency output tells the scheduler that the backlog has grown past a threshold, so it can stop withholding the grant.

Top module: `arf_scheduler`

## Requirements
- R1: The refresh interval is REFI_CYC = floor(WINDOW_US*CLK_MHZ/ROWS) cycles. The first obligation is counted on the REFI_CYC-th rising edge after reset is released, and one more is counted every REFI_CYC edges after that. With an empty backlog and no grant, ref_req rises on the cycle right after that edge.
- R2: ref_req is high from the cycle after the backlog becomes non-zero until the refresh hold-off ends. While ref_gnt stays low, no command other than NOP is driven.
- R3: After the grant, if any bit of bank_open is set, a precharge-all is issued first, encoded as cs_n=0, ras_n=0, cas_n=1, we_n=0 with a10=1.
- R4: The refresh command is encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1 with a10=0. The idle encoding (NOP) is cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0.
- R5: The refresh command comes no earlier than TRP_CYC+1 cycles after the block's own precharge-all. It is only issued after a clock edge at which pre_done was high and bank_open was all zero.
- R6: After the refresh command cycle, ref_req stays high and only NOP is driven for exactly TRFC_CYC cycles. ref_req is low on the cycle after that.
- R7: The backlog goes up by one per interval, saturates at BACKLOG_MAX, and goes down by one per refresh issued. A saturated backlog drains as that many refreshes back to back, with no extra refresh.
- R8: ref_urgent is high exactly when the backlog count exceeds URGENT_TH. It is updated on the edge that changes the count.
- R9: During reset the command outputs show NOP, and ref_req and ref_urgent are low.
- R10: With the grant held, over any long run the number of refreshes issued equals the number of intervals that have elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Main scheduler hands the command bus to this block |
| bank_open | input | NUM_BANKS | One bit per bank, set while a row is open in it |
| pre_done | input | 1 | Every bank has been idle for at least tRP since its latest precharge |
| ref_req | output | 1 | Request for the command bus, held until the hold-off ends |
| ref_urgent | output | 1 | Backlog count is above URGENT_TH |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | All-banks bit, high only for precharge-all |

## Verification
The hardest state to reach from the ports is a saturated backlog above the urgency threshold. Getting there needs the scheduler to refuse the grant for several whole intervals. The bench holds ref_gnt low through five intervals, reads ref_urgent as the count crosses the threshold, then grants the bus. It expects exactly BACKLOG_MAX back-to-back refreshes, each separated by the full hold-off. A second hard case is a refresh held back only by a late precharge-done indication while no bank is open. The bench pulls pre_done low itself just before an interval expires and checks that the refresh follows its release.

// File: rtl/arf_pkg.sv
package arf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_PREA,
    S_TRP,
    S_REF,
    S_RFC
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  localparam dram_cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  localparam dram_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

endpackage

// File: rtl/arf_interval_timer.sv
module arf_interval_timer #(
  parameter int REFI_CYC = 976
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);  // R1

endmodule

// File: rtl/arf_backlog.sv
module arf_backlog #(
  parameter int BACKLOG_MAX = 8,
  parameter int URGENT_TH   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic issue,
  output logic pend_nz,
  output logic urgent
);
  localparam int PW = $clog2(BACKLOG_MAX + 1);
  localparam logic [PW-1:0] FULL = PW'(BACKLOG_MAX);

  logic [PW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (tick && !issue && cnt != FULL)
      cnt_n = cnt + 1'b1;
    else if (issue && !tick && cnt != '0)
      cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      urgent <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      urgent <= (int'(cnt_n) > URGENT_TH);
    end
  end

  assign pend_nz = (cnt != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= BACKLOG_MAX);  // R7
  AST_ISSUE_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (issue && !tick) |=> (cnt == $past(cnt) - 1'b1));  // R7
  AST_URGENT_MATCH: assert property (@(posedge clk) disable iff (rst)
    urgent |-> (int'(cnt) > URGENT_TH));  // R8

endmodule

// File: rtl/arf_seq_fsm.sv
module arf_seq_fsm
  import arf_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TRP_CYC   = 2,
  parameter int TRFC_CYC  = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pend_nz,
  input  logic                 ref_gnt,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 pre_done,
  output logic                 issue,
  output logic                 ref_req,
  output dram_cmd_t            cmd
);
  localparam int MAXC = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_t    state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          all_closed;

  assign all_closed = (bank_open == '0);
  assign issue      = (state == S_REF);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    case (state)
      S_IDLE: if (pend_nz) state_n = S_REQ;
      S_REQ: begin
        if (ref_gnt) begin
          if (!all_closed) begin
            state_n = S_PREA;
          end else begin
            state_n = S_TRP;
            cnt_n   = '0;
          end
        end
      end
      S_PREA: begin
        state_n = S_TRP;
        cnt_n   = CW'(TRP_CYC - 1);
      end
      S_TRP: begin
        if (cnt != '0)                  cnt_n   = cnt - 1'b1;
        else if (pre_done && all_closed) state_n = S_REF;
      end
      S_REF: begin
        state_n = S_RFC;
        cnt_n   = CW'(TRFC_CYC - 1);
      end
      S_RFC: begin
        if (cnt != '0) cnt_n   = cnt - 1'b1;
        else           state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      ref_req <= 1'b0;
      cmd     <= CMD_NOP;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      ref_req <= (state_n != S_IDLE);
      if (state_n == S_PREA)     cmd <= CMD_PREA;
      else if (state_n == S_REF) cmd <= CMD_REF;
      else                       cmd <= CMD_NOP;
    end
  end

  AST_CMD_NEEDS_BUS: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |-> ref_req);  // R2
  AST_REF_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> ($past(pre_done) && ($past(bank_open) == '0)));  // R5
  AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |=> ((cmd == CMD_NOP) && ref_req));  // R6
  AST_PREA_THEN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PREA) |=> (cmd == CMD_NOP));  // R3

endmodule

// File: rtl/arf_scheduler.sv
module arf_scheduler
  import arf_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int WINDOW_US   = 64000,
  parameter int CLK_MHZ     = 125,
  parameter int ROWS        = 8192,
  parameter int TRP_CYC     = 2,
  parameter int TRFC_CYC    = 25,
  parameter int BACKLOG_MAX = 8,
  parameter int URGENT_TH   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_gnt,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 pre_done,
  output logic                 ref_req,
  output logic                 ref_urgent,
  output logic                 cmd_cs_n,
  output logic                 cmd_ras_n,
  output logic                 cmd_cas_n,
  output logic                 cmd_we_n,
  output logic                 cmd_a10
);
  localparam int REFI_CYC = (WINDOW_US * CLK_MHZ) / ROWS;

  logic      tick, issue, pend_nz;
  dram_cmd_t cmd;

  arf_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  arf_backlog #(.BACKLOG_MAX(BACKLOG_MAX), .URGENT_TH(URGENT_TH)) u_backlog (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .issue   (issue),
    .pend_nz (pend_nz),
    .urgent  (ref_urgent)
  );

  arf_seq_fsm #(.NUM_BANKS(NUM_BANKS), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pend_nz   (pend_nz),
    .ref_gnt   (ref_gnt),
    .bank_open (bank_open),
    .pre_done  (pre_done),
    .issue     (issue),
    .ref_req   (ref_req),
    .cmd       (cmd)
  );

  assign cmd_cs_n  = cmd.cs_n;
  assign cmd_ras_n = cmd.ras_n;
  assign cmd_cas_n = cmd.cas_n;
  assign cmd_we_n  = cmd.we_n;
  assign cmd_a10   = cmd.a10;

endmodule

// File: tb/sim_arf_scheduler.sv
`timescale 1ns/1ps
module sim_arf_scheduler;
  localparam int NB    = 8;
  localparam int TRP   = 4;
  localparam int TRFC  = 12;
  localparam int BMAX  = 4;
  localparam int UTH   = 2;
  localparam int REFI  = 250;   // 64 * 125 / 32
  localparam logic [4:0] P_NOP = 5'b01110;
  localparam logic [4:0] P_PRE = 5'b00101;
  localparam logic [4:0] P_REF = 5'b00010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_gnt = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic pre_done = 1'b1;
  logic ref_req, ref_urgent, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;

  int cyc = 0;
  int vectors = 0;
  int miscompares = 0;
  int pre_release = 0;
  int refs = 0;
  int last_pre_cyc = -100;
  int last_ref_cyc = -100;
  int pd_low_cyc = -100;
  int hold = -1;
  logic [4:0] exp_q[$];

  always #4 clk = ~clk;

  arf_scheduler #(
    .NUM_BANKS(NB), .WINDOW_US(64), .CLK_MHZ(125), .ROWS(32),
    .TRP_CYC(TRP), .TRFC_CYC(TRFC), .BACKLOG_MAX(BMAX), .URGENT_TH(UTH)
  ) u0 (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .bank_open(bank_open),
    .pre_done(pre_done), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_a10(cmd_a10)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // precharge tracker model: done again TRP cycles after a precharge
  always @(posedge clk) begin
    #1 pre_done = (cyc >= pre_release);
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic push_exp(input logic [4:0] p);
    exp_q.push_back(p);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: compares observed commands against the expected queue
  always @(negedge clk) begin
    logic [4:0] pat;
    logic [4:0] exp_p;
    if (!rst) begin
      pat = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10};
      if (!pre_done) pd_low_cyc = cyc;
      if (hold > 0) begin
        check("R6 hold-off req", int'(ref_req), 1);
        check("R6 hold-off nop", int'(pat), int'(P_NOP));
        hold--;
      end else if (hold == 0) begin
        check("R6 release", int'(ref_req), 0);
        hold = -1;
      end
      if (pat != P_NOP) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected command", int'(pat), int'(P_NOP));
        end else begin
          exp_p = exp_q.pop_front();
          check((exp_p == P_PRE) ? "R3 precharge-all encoding" : "R4 refresh encoding",
                int'(pat), int'(exp_p));
        end
        if (pat == P_PRE) begin
          last_pre_cyc = cyc;
          pre_release  = cyc + TRP;
          bank_open    = '0;
        end else if (pat == P_REF) begin
          refs++;
          if (last_pre_cyc > last_ref_cyc)
            check("R5 gap after precharge", int'(cyc - last_pre_cyc >= TRP + 1), 1);
          check("R5 after pre_done", int'(pd_low_cyc < cyc - 1), 1);
          last_ref_cyc = cyc;
          hold = TRFC;
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    check("R9 reset cmd", int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10}), int'(P_NOP));
    check("R9 reset req", int'(ref_req), 0);
    check("R9 reset urgent", int'(ref_urgent), 0);
    rst = 1'b0;

    // first interval, grant withheld
    wait_cyc(250);
    check("R1 before first interval", int'(ref_req), 0);
    wait_cyc(251);
    check("R1 req after first interval", int'(ref_req), 1);
    wait_cyc(600);
    check("R8 backlog 2 not urgent", int'(ref_urgent), 0);
    check("R2 req held without grant", int'(ref_req), 1);
    wait_cyc(800);
    check("R8 backlog 3 urgent", int'(ref_urgent), 1);
    wait_cyc(1300);
    check("R8 saturated urgent", int'(ref_urgent), 1);

    // grant: saturated backlog drains
    for (int i = 0; i < BMAX; i++) push_exp(P_REF);
    ref_gnt = 1'b1;
    wait_cyc(1450);
    check("R7 drained count", exp_q.size(), 0);
    check("R7 urgent cleared", int'(ref_urgent), 0);
    check("R6 bus released", int'(ref_req), 0);

    // open banks: precharge-all first
    wait_cyc(1460);
    bank_open = 8'h05;
    push_exp(P_PRE);
    push_exp(P_REF);
    wait_cyc(1600);
    check("R3 precharge then refresh", exp_q.size(), 0);

    // late precharge-done with all banks closed
    wait_cyc(1700);
    pre_release = 1780;
    push_exp(P_REF);
    wait_cyc(1779);
    check("R5 waits for pre_done", exp_q.size(), 1);
    wait_cyc(1790);
    check("R5 refresh after pre_done", exp_q.size(), 0);
    check("R5 refresh cycle", last_ref_cyc, 1781);

    // long run rate
    wait_cyc(1800);
    for (int i = 0; i < 101; i++) push_exp(P_REF);
    wait_cyc(2100);
    r0 = refs;
    wait_cyc(27100);
    check("R10 refreshes per window", refs - r0, 100);
    check("R10 queue drained", exp_q.size(), 0);

    finish_run();
  end

endmodule